// File: doc/BRIEF.md
# Synchronous Byte-Lane SRAM with Flow-Through or Registered Read Path

This block is a synthesizable model of a synchronous static RAM. The depth is set by a parameter, and each word is made of byte lanes of 9 bits, two lanes by default. An external burst sequencer supplies one address per clock, so a burst is simply one command per cycle. Every synchronous control is sampled on the rising clock. These controls are three chip enables, a global write strobe, a byte-write strobe and one select per lane. Writes complete in the same edge that samples them.

The read data path has two variants, chosen by a static mode input. In flow-through mode the word that the registered address points to goes straight to the output. In registered mode the word passes through an extra output register first. A drive-enable output stands in for the tristate pad buffers. The turn-off of the drive is pipelined two deep, so it lags a deselect by one extra cycle in both modes. The output-enable and sleep inputs act asynchronously on the drive. While sleep is asserted the block ignores every command and keeps its contents.

Top module: `dcd_sync_sram`

## Requirements
- R1: The device is selected only when `en0_n`=0, `en1`=1 and `en2_n`=0. In any other cycle it neither reads nor writes, and a write presented while deselected leaves memory unchanged.
- R2: With `pipe_mode`=0 (flow-through), a read sampled at edge k gives `dout` equal to the addressed word with `drive`=1 before edge k+1. Back-to-back reads give a new word every cycle (2-1-1-1).
- R3: With `pipe_mode`=1 (registered), a read sampled at edge k has `drive`=0 before edge k+1 when no read preceded it. Its data appears with `drive`=1 after edge k+1. Back-to-back reads then give one word per cycle (3-1-1-1).
- R4: When the last read is followed by a non-read cycle sampled at edge d, `drive` stays 1 until edge d+1 and is 0 after it, in both modes.
- R5: With `gw_n`=1 and `bw_n`=0, lane i is written exactly when `lane_n[i]`=0. Lane 0 is `din[8:0]` and lane 1 is `din[17:9]`. Unselected lanes keep their old value.
- R6: With `gw_n`=0, all lanes are written whatever the values of `bw_n` and `lane_n`.
- R7: A read in the cycle after a write to the same address returns the new word. Two consecutive write cycles after an idle period leave `drive`=0.
- R8: `oe_n`=1 forces `drive` to 0 at once, without a clock edge. Returning it to 0 restores `drive` and the same `dout` without a clock edge.
- R9: `zz`=1 forces `drive` to 0 at once. Reads and writes sampled while `zz`=1 are ignored and memory is kept. The first edge after `zz` falls samples commands normally.
- R10: A selected cycle with `gw_n`=0 or `bw_n`=0 is a write and never drives the output. A write with `bw_n`=0 and no lane selected changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the read pipeline |
| pipe_mode | input | 1 | 0 = flow-through read, 1 = registered read; held static |
| en0_n | input | 1 | Chip enable, active low |
| en1 | input | 1 | Chip enable, active high |
| en2_n | input | 1 | Chip enable, active low |
| addr | input | ADDR_W | Word address from the burst sequencer |
| din | input | LANES*LANE_W | Write data |
| gw_n | input | 1 | Global write, active low |
| bw_n | input | 1 | Byte-write strobe, active low |
| lane_n | input | LANES | Per-lane write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| zz | input | 1 | Asynchronous sleep, active high |
| dout | output | LANES*LANE_W | Read data |
| drive | output | 1 | Read data valid and pad drive enable |

## Verification
A lane-mask decode error shows up as a wrong merged word on the first read of the written address. In flow-through mode that read comes one cycle after the write. A stage register of the read pipeline that is stuck or skipped moves `drive` by a whole cycle. That error is visible on the edge right after the first read of a burst, or on the edge right after a deselect. A leak of commands through sleep, or through a deasserted enable, corrupts a stored word. The bench sees it on the first read after the block wakes up.

// File: rtl/dcd_sram_pkg.sv
`timescale 1ns/1ps
package dcd_sram_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // all three enables must be active together
  function automatic logic chip_on(input logic en0_n, input logic en1, input logic en2_n);
    return ~en0_n & en1 & ~en2_n;
  endfunction

  // command kind for one sampled cycle
  function automatic op_e decode_op(input logic on, input logic sleep,
                                    input logic gw_n, input logic bw_n);
    if (!on || sleep)      return OP_NONE;
    if (!gw_n || !bw_n)    return OP_WRITE;
    return OP_READ;
  endfunction

  // a lane is written on a global write or when its own select is low
  function automatic logic lane_hit(input logic gw_n, input logic sel_n);
    return ~gw_n | ~sel_n;
  endfunction

  // drive before async gating: registered mode follows stage 2 only,
  // flow-through keeps driving while either stage holds a read
  function automatic logic core_drive(input logic pipe, input logic s1, input logic s2);
    return pipe ? s2 : (s1 | s2);
  endfunction

endpackage

// File: rtl/dcd_sram_decode.sv
`timescale 1ns/1ps
module dcd_sram_decode
  import dcd_sram_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             en0_n,
  input  logic             en1,
  input  logic             en2_n,
  input  logic             zz,
  input  logic             gw_n,
  input  logic             bw_n,
  input  logic [LANES-1:0] lane_n,
  output logic             rd_go,
  output logic             wr_go,
  output logic [LANES-1:0] wr_mask
);

  logic selected;
  op_e  op;

  assign selected = chip_on(en0_n, en1, en2_n);
  assign op       = decode_op(selected, zz, gw_n, bw_n);
  assign rd_go    = (op == OP_READ);
  assign wr_go    = (op == OP_WRITE);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign wr_mask[g] = wr_go & lane_hit(gw_n, lane_n[g]);
  end

endmodule

// File: rtl/dcd_sram_array.sv
`timescale 1ns/1ps
module dcd_sram_array #(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                      clk,
  input  logic                      wr_go,
  input  logic [LANES-1:0]          wr_mask,
  input  logic [ADDR_W-1:0]         waddr,
  input  logic [LANES*LANE_W-1:0]   wdata,
  input  logic [ADDR_W-1:0]         raddr,
  output logic [LANES*LANE_W-1:0]   rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_go && wr_mask[g]) begin
        mem[waddr] <= wdata[g*LANE_W +: LANE_W];
      end
    end

    assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
  end

endmodule

// File: rtl/dcd_sram_outpipe.sv
`timescale 1ns/1ps
module dcd_sram_outpipe
  import dcd_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_mode,
  input  logic              oe_n,
  input  logic              zz,
  input  logic              rd_go,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] rdata,
  output logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] dout,
  output logic              drive,
  output logic              stage1,
  output logic              stage2
);

  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] data_q;
  logic              v1_q;
  logic              v2_q;

  // stage 1: address capture, held across non-read cycles
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      v1_q   <= 1'b0;
    end else begin
      v1_q <= rd_go;
      if (rd_go) addr_q <= addr;
    end
  end

  // stage 2: output register and the second deselect stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      v2_q   <= 1'b0;
    end else begin
      v2_q <= v1_q & ~zz;
      if (v1_q) data_q <= rdata;
    end
  end

  assign raddr  = addr_q;
  assign dout   = pipe_mode ? data_q : rdata;
  assign drive  = core_drive(pipe_mode, v1_q, v2_q) & ~oe_n & ~zz;
  assign stage1 = v1_q;
  assign stage2 = v2_q;

endmodule

// File: rtl/dcd_sync_sram.sv
`timescale 1ns/1ps
module dcd_sync_sram #(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pipe_mode,
  input  logic                    en0_n,
  input  logic                    en1,
  input  logic                    en2_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] din,
  input  logic                    gw_n,
  input  logic                    bw_n,
  input  logic [LANES-1:0]        lane_n,
  input  logic                    oe_n,
  input  logic                    zz,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    drive
);

  localparam int WORD_W = LANES * LANE_W;

  // named internal events, observed by the bound checker
  logic              rd_go;
  logic              wr_go;
  logic [LANES-1:0]  wr_mask;
  logic [ADDR_W-1:0] raddr;
  logic [WORD_W-1:0] rdata;
  logic              stage1;
  logic              stage2;

  dcd_sram_decode #(.LANES(LANES)) u_dec (
    .en0_n   (en0_n),
    .en1     (en1),
    .en2_n   (en2_n),
    .zz      (zz),
    .gw_n    (gw_n),
    .bw_n    (bw_n),
    .lane_n  (lane_n),
    .rd_go   (rd_go),
    .wr_go   (wr_go),
    .wr_mask (wr_mask)
  );

  dcd_sram_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_mem (
    .clk     (clk),
    .wr_go   (wr_go),
    .wr_mask (wr_mask),
    .waddr   (addr),
    .wdata   (din),
    .raddr   (raddr),
    .rdata   (rdata)
  );

  dcd_sram_outpipe #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .pipe_mode (pipe_mode),
    .oe_n      (oe_n),
    .zz        (zz),
    .rd_go     (rd_go),
    .addr      (addr),
    .rdata     (rdata),
    .raddr     (raddr),
    .dout      (dout),
    .drive     (drive),
    .stage1    (stage1),
    .stage2    (stage2)
  );

endmodule

// File: rtl/dcd_sync_sram_chk.sv
`timescale 1ns/1ps
module dcd_sync_sram_chk #(
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pipe_mode,
  input logic             en0_n,
  input logic             en1,
  input logic             en2_n,
  input logic             gw_n,
  input logic [LANES-1:0] lane_n,
  input logic             oe_n,
  input logic             zz,
  input logic             drive,
  input logic             rd_go,
  input logic             wr_go,
  input logic [LANES-1:0] wr_mask,
  input logic             stage1,
  input logic             stage2
);

  AST_DESEL_NO_OP:   assert property (@(posedge clk) disable iff (!rst_n) !(!en0_n && en1 && !en2_n) |-> (!rd_go && !wr_go)); // R1
  AST_READ_STAGE:    assert property (@(posedge clk) disable iff (!rst_n) rd_go |=> stage1); // R2
  AST_PIPE_FIRST:    assert property (@(posedge clk) disable iff (!rst_n) (pipe_mode && stage1 && !stage2) |-> !drive); // R3
  AST_DESEL_HOLD:    assert property (@(posedge clk) disable iff (!rst_n) (stage1 && !zz) |=> stage2); // R4
  AST_BYTE_LANES:    assert property (@(posedge clk) disable iff (!rst_n) (gw_n && wr_go) |-> (wr_mask == ~lane_n)); // R5
  AST_GLOBAL_ALL:    assert property (@(posedge clk) disable iff (!rst_n) (!gw_n && wr_go) |-> (&wr_mask)); // R6
  AST_WRITE_NO_RD:   assert property (@(posedge clk) disable iff (!rst_n) wr_go |=> !stage1); // R7
  AST_OE_OFF:        assert property (@(posedge clk) disable iff (!rst_n) oe_n |-> !drive); // R8
  AST_SLEEP_OFF:     assert property (@(posedge clk) disable iff (!rst_n) zz |-> !drive); // R9
  AST_SLEEP_NO_OP:   assert property (@(posedge clk) disable iff (!rst_n) zz |-> (!rd_go && !wr_go && (wr_mask == '0))); // R9
  AST_OP_EXCLUSIVE:  assert property (@(posedge clk) disable iff (!rst_n) !(rd_go && wr_go)); // R10

endmodule

bind dcd_sync_sram dcd_sync_sram_chk #(.LANES(LANES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pipe_mode (pipe_mode),
  .en0_n     (en0_n),
  .en1       (en1),
  .en2_n     (en2_n),
  .gw_n      (gw_n),
  .lane_n    (lane_n),
  .oe_n      (oe_n),
  .zz        (zz),
  .drive     (drive),
  .rd_go     (rd_go),
  .wr_go     (wr_go),
  .wr_mask   (wr_mask),
  .stage1    (stage1),
  .stage2    (stage2)
);

// File: tb/dcd_sync_sram_test.sv
`timescale 1ns/1ps
module dcd_sync_sram_test;

  localparam int AW    = 6;
  localparam int LW    = 9;
  localparam int NL    = 2;
  localparam int WW    = NL * LW;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          pipe_mode;
  logic          en0_n, en1, en2_n;
  logic [AW-1:0] addr;
  logic [WW-1:0] din;
  logic          gw_n, bw_n;
  logic [NL-1:0] lane_n;
  logic          oe_n, zz;
  logic [WW-1:0] dout;
  logic          drive;

  int  n_run  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;
  logic [WW-1:0] model [DEPTH];

  always #2 clk = ~clk;

  dcd_sync_sram #(.ADDR_W(AW), .LANE_W(LW), .LANES(NL)) uut (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode),
    .en0_n(en0_n), .en1(en1), .en2_n(en2_n),
    .addr(addr), .din(din), .gw_n(gw_n), .bw_n(bw_n), .lane_n(lane_n),
    .oe_n(oe_n), .zz(zz), .dout(dout), .drive(drive)
  );

  function automatic logic [WW-1:0] pat(input int a, input int s);
    return WW'((a * 2731 + s * 977 + 13) ^ (a << 11) ^ (s << 5));
  endfunction

  function automatic logic [WW-1:0] merge(input logic [WW-1:0] old_w,
                                          input logic [WW-1:0] new_w,
                                          input logic [NL-1:0] m);
    logic [WW-1:0] r;
    r = old_w;
    for (int i = 0; i < NL; i++) begin
      if (m[i]) r[i*LW +: LW] = new_w[i*LW +: LW];
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic sel_on;
    en0_n = 1'b0; en1 = 1'b1; en2_n = 1'b0;
  endtask

  task automatic go_idle;
    en0_n = 1'b0; en1 = 1'b0; en2_n = 1'b0;
    gw_n = 1'b1; bw_n = 1'b1; lane_n = '1;
  endtask

  task automatic issue_read(input int a);
    sel_on();
    gw_n = 1'b1; bw_n = 1'b1; lane_n = '1;
    addr = AW'(a);
  endtask

  task automatic issue_gw(input int a, input logic [WW-1:0] d);
    sel_on();
    gw_n = 1'b0; bw_n = 1'b1; lane_n = '1;
    addr = AW'(a); din = d;
  endtask

  task automatic issue_bw(input int a, input logic [WW-1:0] d, input logic [NL-1:0] m);
    sel_on();
    gw_n = 1'b1; bw_n = 1'b0; lane_n = ~m;
    addr = AW'(a); din = d;
  endtask

  task automatic flow_read_check(input int a, input string req);
    issue_read(a);
    step();
    check(req, 32'(dout), 32'(model[a]));
    check(req, 32'(drive), 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pipe_mode = 1'b0; oe_n = 1'b0; zz = 1'b0;
    addr = '0; din = '0;
    go_idle();
    repeat (3) step();
    check("R2 reset drive", 32'(drive), 32'd0);
    rst_n = 1'b1;
    step();

    // fill with global writes
    for (int a = 0; a < DEPTH; a++) begin
      issue_gw(a, pat(a, 1));
      model[a] = pat(a, 1);
      step();
    end
    go_idle(); step(); step();
    check("R7 writes never drive", 32'(drive), 32'd0);

    // flow-through burst over every address
    for (int a = 0; a < DEPTH; a++) begin
      flow_read_check(a, "R2 flow read");
    end
    go_idle();
    step();
    check("R4 flow hold after deselect", 32'(drive), 32'd1);
    step();
    check("R4 flow off after second edge", 32'(drive), 32'd0);

    // registered-mode burst
    pipe_mode = 1'b1;
    for (int a = 0; a < DEPTH; a++) begin
      issue_read(a);
      step();
      if (a == 0) begin
        check("R3 first word not yet driven", 32'(drive), 32'd0);
      end else begin
        check("R3 pipe data", 32'(dout), 32'(model[a-1]));
        check("R3 pipe drive", 32'(drive), 32'd1);
      end
    end
    go_idle();
    step();
    check("R3 pipe last data", 32'(dout), 32'(model[DEPTH-1]));
    check("R4 pipe hold after deselect", 32'(drive), 32'd1);
    step();
    check("R4 pipe off after second edge", 32'(drive), 32'd0);
    pipe_mode = 1'b0;

    // every byte-write lane mask
    for (int m = 0; m < (1 << NL); m++) begin
      int a;
      a = 10 + m;
      go_idle(); step(); step();
      issue_bw(a, pat(a, 7), NL'(m));
      model[a] = merge(model[a], pat(a, 7), NL'(m));
      step();
      check("R10 byte write does not drive", 32'(drive), 32'd0);
      flow_read_check(a, "R5 lane mask merge");
    end

    // global write overrides the byte controls
    sel_on(); gw_n = 1'b0; bw_n = 1'b0; lane_n = '1;
    addr = AW'(20); din = pat(20, 9); model[20] = pat(20, 9);
    step();
    flow_read_check(20, "R6 global over empty lane mask");
    sel_on(); gw_n = 1'b0; bw_n = 1'b1; lane_n = NL'(2);
    addr = AW'(21); din = pat(21, 9); model[21] = pat(21, 9);
    step();
    flow_read_check(21, "R6 global ignores lane selects");

    // write then immediate read, and back-to-back writes
    issue_gw(30, pat(30, 4)); model[30] = pat(30, 4);
    step();
    flow_read_check(30, "R7 read after write");
    go_idle(); step(); step();
    issue_gw(31, pat(31, 4)); model[31] = pat(31, 4);
    step();
    issue_gw(32, pat(32, 4)); model[32] = pat(32, 4);
    step();
    check("R7 two writes no drive", 32'(drive), 32'd0);
    go_idle(); step();
    flow_read_check(31, "R7 write data 31");
    flow_read_check(32, "R7 write data 32");

    // each enable alone deselects
    for (int k = 0; k < 3; k++) begin
      int a;
      a = 40 + k;
      go_idle(); step(); step();
      issue_gw(a, pat(a, 99));
      if (k == 0) en0_n = 1'b1;
      if (k == 1) en1   = 1'b0;
      if (k == 2) en2_n = 1'b1;
      step();
      gw_n = 1'b1;
      step();
      check("R1 deselected read no drive", 32'(drive), 32'd0);
      flow_read_check(a, "R1 deselected write ignored");
    end

    // asynchronous output enable
    flow_read_check(5, "R2 read before oe test");
    go_idle();
    oe_n = 1'b1;
    #0.5;
    check("R8 oe off immediate", 32'(drive), 32'd0);
    oe_n = 1'b0;
    #0.5;
    check("R8 oe restore drive", 32'(drive), 32'd1);
    check("R8 oe restore data", 32'(dout), 32'(model[5]));
    step(); step();

    // sleep: async turn-off, commands ignored, contents kept
    flow_read_check(6, "R2 read before sleep");
    zz = 1'b1;
    #0.5;
    check("R9 sleep off immediate", 32'(drive), 32'd0);
    @(negedge clk);
    issue_gw(6, pat(6, 55));
    step();
    issue_read(7);
    step();
    issue_bw(7, pat(7, 55), '1);
    step();
    go_idle();
    zz = 1'b0;
    #0.5;
    check("R9 reads in sleep ignored", 32'(drive), 32'd0);
    @(negedge clk);
    flow_read_check(6, "R9 contents kept word 6");
    flow_read_check(7, "R9 contents kept word 7");
    go_idle(); step(); step();

    done = 1'b1;
    summary();
    $finish;
  end

endmodule